// File: doc/BRIEF.md
# Streaming Symmetric Image Pyramid Sampler

This block takes a raster pixel stream with frame and line qualifiers and builds sixteen downscaled copies of the image at the same time, without storing any part of the frame. The frame is cut into square tiles of `PATCH` x `PATCH` pixels, 16 x 16 by default. Each output level picks out a fixed set of column offsets and row offsets inside every tile. On any pixel that falls on one of those offsets, the level raises its own strobe. The pixel word is forwarded unchanged, so every level shares the same data bus and only the strobes differ.

Level k, counted from 1 to 16, keeps k columns and k rows of every tile. With the default 640 x 480 input, the levels therefore run from 40 x 30 up to the full frame. Levels k and 16-k form a pair, and their offset sets complement each other. This means that at most one member of each pair is active on any pixel, so a downstream stage that serves a pair can be shared between its two members. Each active level also reports the coordinate of the current pixel inside its own downscaled image. Everything runs on the pixel clock, and all outputs come from one register stage.

Top module: `pyramid_sampler`

## Requirements
- R1: While rst_ni is low, every level strobe, frame_valid_o, line_valid_o and pix_o are zero.
- R2: pix_o, frame_valid_o and line_valid_o repeat pix_i, frame_valid_i and line_valid_i with exactly one clock of delay.
- R3: For level k with k <= PATCH/2, an in-tile offset i (0..PATCH-1) is selected when floor((i+1)*k/PATCH) differs from floor(i*k/PATCH). Equivalently, the selected offsets are ceil(PATCH*j/k)-1 for j = 1..k.
- R4: For level k > PATCH/2, the selected offsets are exactly the offsets that level PATCH-k does not select. Level PATCH therefore selects every offset, and in each pair (k, PATCH-k) for k = 1..PATCH/2-1 the two strobes are never high in the same cycle.
- R5: The column counter restarts at 0 on the first pixel after line_valid_i has been low, and it advances by one on each cycle in which line_valid_i is high.
- R6: The row counter restarts at 0 while frame_valid_i is low, and it advances by one on each falling edge of line_valid_i that occurs while frame_valid_i is high.
- R7: Strobe bit k-1 of lvl_valid_o carries level k. Its coordinate field is bits [(k-1)*XW +: XW] of lvl_x_o and bits [(k-1)*YW +: YW] of lvl_y_o, with XW = clog2(FRAME_W) and YW = clog2(FRAME_H). The x value is tile_column*k plus the number of selected offsets below the pixel's in-tile column, and the y value is formed the same way from rows.
- R8: No level strobe is raised for a pixel that has frame_valid_i or line_valid_i low.
- R9: A level strobes only when both the in-tile column and the in-tile row are selected offsets of that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Frame qualifier |
| line_valid_i | input | 1 | Line qualifier |
| pix_i | input | DATA_W | Pixel word |
| frame_valid_o | output | 1 | Delayed frame qualifier |
| line_valid_o | output | 1 | Delayed line qualifier |
| pix_o | output | DATA_W | Delayed pixel word, shared by all levels |
| lvl_valid_o | output | PATCH | Per-level sample strobe, bit k-1 for level k |
| lvl_x_o | output | PATCH*XW | Per-level downscaled column |
| lvl_y_o | output | PATCH*YW | Per-level downscaled row |

## Verification
Every output is due one clock after the input pixel that produces it. The bench drives its inputs on the falling edge and, at the next falling edge, compares all outputs with a prediction it stored for the pixel it drove one step earlier. That prediction is built from offset tables derived from the ceil form in R3 together with absolute pixel indices, so the bench never reuses the floor test that the design applies. Full frames of a reduced size are swept with different blanking lengths, and a line-valid burst outside the frame is included, so every pixel of every level is compared.

// File: rtl/pyr_pkg.sv
package pyr_pkg;

  // floor-step test: offset i starts a new sample slot for k of n
  function automatic logic step_hit(input int k, input int i, input int n);
    return (((i + 1) * k) / n) != ((i * k) / n);
  endfunction

  // upper levels are the complement of their partner so pairs never collide
  function automatic logic lvl_hit(input int k, input int i, input int n);
    if (2 * k <= n) return step_hit(k, i, n);
    return !step_hit(n - k, i, n);
  endfunction

  // number of selected offsets below i
  function automatic int lvl_rank(input int k, input int i, input int n);
    if (2 * k <= n) return (i * k) / n;
    return i - (i * (n - k)) / n;
  endfunction

endpackage

// File: rtl/pyr_axis_cnt.sv
module pyr_axis_cnt #(
  parameter int SUB_N = 16,
  parameter int SPAN  = 40,
  localparam int SW   = $clog2(SUB_N),
  localparam int PW   = $clog2(SPAN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [SW-1:0] sub_o,
  output logic [PW-1:0] patch_o
);

  localparam logic [SW-1:0] SUB_LAST   = SW'(SUB_N - 1);
  localparam logic [PW-1:0] PATCH_LAST = PW'(SPAN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_o   <= '0;
      patch_o <= '0;
    end else if (clr_i) begin
      sub_o   <= '0;
      patch_o <= '0;
    end else if (adv_i) begin
      if (sub_o == SUB_LAST) begin
        sub_o   <= '0;
        patch_o <= (patch_o == PATCH_LAST) ? '0 : patch_o + PW'(1);
      end else begin
        sub_o <= sub_o + SW'(1);
      end
    end
  end

endmodule

// File: rtl/pyr_level_lane.sv
module pyr_level_lane import pyr_pkg::*; #(
  parameter int N  = 16,
  parameter int K  = 1,
  parameter int CW = 6,
  parameter int RW = 5,
  parameter int XW = 10,
  parameter int YW = 9,
  localparam int SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [SW-1:0] sub_x_i,
  input  logic [CW-1:0] patch_x_i,
  input  logic [SW-1:0] sub_y_i,
  input  logic [RW-1:0] patch_y_i,
  output logic          valid_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);

  logic          hit;
  logic [XW-1:0] x_nx;
  logic [YW-1:0] y_nx;

  always_comb begin
    hit  = act_i && lvl_hit(K, int'(sub_x_i), N) && lvl_hit(K, int'(sub_y_i), N);
    x_nx = XW'(int'(patch_x_i) * K + lvl_rank(K, int'(sub_x_i), N));
    y_nx = YW'(int'(patch_y_i) * K + lvl_rank(K, int'(sub_y_i), N));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= hit;
      if (hit) begin
        x_o <= x_nx;
        y_o <= y_nx;
      end
    end
  end

endmodule

// File: rtl/pyramid_sampler.sv
module pyramid_sampler #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int PATCH   = 16,
  localparam int LEVELS = PATCH,
  localparam int XW     = $clog2(FRAME_W),
  localparam int YW     = $clog2(FRAME_H)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_valid_i,
  input  logic                 line_valid_i,
  input  logic [DATA_W-1:0]    pix_i,
  output logic                 frame_valid_o,
  output logic                 line_valid_o,
  output logic [DATA_W-1:0]    pix_o,
  output logic [LEVELS-1:0]    lvl_valid_o,
  output logic [LEVELS*XW-1:0] lvl_x_o,
  output logic [LEVELS*YW-1:0] lvl_y_o
);

  localparam int PCOLS = FRAME_W / PATCH;
  localparam int PROWS = FRAME_H / PATCH;
  localparam int SW    = $clog2(PATCH);
  localparam int CW    = $clog2(PCOLS + 1);
  localparam int RW    = $clog2(PROWS + 1);

  logic          lv_q;
  logic          pix_act;
  logic          row_end;
  logic [SW-1:0] sub_x, sub_y;
  logic [CW-1:0] patch_x;
  logic [RW-1:0] patch_y;

  assign pix_act = frame_valid_i && line_valid_i;
  assign row_end = frame_valid_i && lv_q && !line_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q          <= 1'b0;
      frame_valid_o <= 1'b0;
      line_valid_o  <= 1'b0;
      pix_o         <= '0;
    end else begin
      lv_q          <= line_valid_i;
      frame_valid_o <= frame_valid_i;
      line_valid_o  <= line_valid_i;
      pix_o         <= pix_i;
    end
  end

  pyr_axis_cnt #(.SUB_N(PATCH), .SPAN(PCOLS)) i_col_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!line_valid_i),
    .adv_i   (line_valid_i),
    .sub_o   (sub_x),
    .patch_o (patch_x)
  );

  pyr_axis_cnt #(.SUB_N(PATCH), .SPAN(PROWS)) i_row_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!frame_valid_i),
    .adv_i   (row_end),
    .sub_o   (sub_y),
    .patch_o (patch_y)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pyr_level_lane #(
      .N (PATCH), .K (g + 1), .CW (CW), .RW (RW), .XW (XW), .YW (YW)
    ) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (pix_act),
      .sub_x_i   (sub_x),
      .patch_x_i (patch_x),
      .sub_y_i   (sub_y),
      .patch_y_i (patch_y),
      .valid_o   (lvl_valid_o[g]),
      .x_o       (lvl_x_o[g*XW +: XW]),
      .y_o       (lvl_y_o[g*YW +: YW])
    );
  end

endmodule

// File: rtl/pyramid_sampler_chk.sv
module pyramid_sampler_chk #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int PATCH   = 16,
  localparam int LEVELS = PATCH,
  localparam int XW     = $clog2(FRAME_W),
  localparam int YW     = $clog2(FRAME_H)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_valid_i,
  input logic                 line_valid_i,
  input logic [DATA_W-1:0]    pix_i,
  input logic                 frame_valid_o,
  input logic                 line_valid_o,
  input logic [DATA_W-1:0]    pix_o,
  input logic [LEVELS-1:0]    lvl_valid_o,
  input logic [LEVELS*XW-1:0] lvl_x_o,
  input logic [LEVELS*YW-1:0] lvl_y_o
);

  logic          seen;
  logic          full_v;
  logic [XW-1:0] full_x;
  logic [YW-1:0] full_y;

  assign full_v = lvl_valid_o[LEVELS-1];
  assign full_x = lvl_x_o[(LEVELS-1)*XW +: XW];
  assign full_y = lvl_y_o[(LEVELS-1)*YW +: YW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (lvl_valid_o == '0 && !frame_valid_o && !line_valid_o); // R1
    end
  end

  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (pix_o == $past(pix_i) && line_valid_o == $past(line_valid_i))); // R2

  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !$past(frame_valid_i && line_valid_i)) |-> lvl_valid_o == '0); // R8

  AST_FULL_EVERY_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> full_v == $past(frame_valid_i && line_valid_i)); // R4

  AST_FULL_X_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && full_v && $past(full_v)) |-> full_x == $past(full_x) + XW'(1)); // R5

  AST_FULL_X_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && full_v && !$past(line_valid_o)) |-> full_x == '0); // R5

  AST_FULL_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && full_v && $past(full_v)) |-> full_y == $past(full_y)); // R6

  for (genvar k = 1; k < LEVELS / 2; k++) begin : g_pair
    AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lvl_valid_o[k-1] && lvl_valid_o[LEVELS-k-1])); // R4
  end

endmodule

bind pyramid_sampler pyramid_sampler_chk #(
  .DATA_W (DATA_W), .FRAME_W (FRAME_W), .FRAME_H (FRAME_H), .PATCH (PATCH)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .line_valid_i  (line_valid_i),
  .pix_i         (pix_i),
  .frame_valid_o (frame_valid_o),
  .line_valid_o  (line_valid_o),
  .pix_o         (pix_o),
  .lvl_valid_o   (lvl_valid_o),
  .lvl_x_o       (lvl_x_o),
  .lvl_y_o       (lvl_y_o)
);

// File: tb/test_pyramid_sampler.sv
module test_pyramid_sampler;

  localparam int DW = 8;
  localparam int FW = 64;
  localparam int FH = 48;
  localparam int PN = 16;
  localparam int XW = $clog2(FW);
  localparam int YW = $clog2(FH);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              frame_valid_i = 1'b0;
  logic              line_valid_i = 1'b0;
  logic [DW-1:0]     pix_i = '0;
  logic              frame_valid_o, line_valid_o;
  logic [DW-1:0]     pix_o;
  logic [PN-1:0]     lvl_valid_o;
  logic [PN*XW-1:0]  lvl_x_o;
  logic [PN*YW-1:0]  lvl_y_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit hit_t [0:PN][0:PN-1];
  int rank_t[0:PN][0:PN-1];

  logic          p_fv = 1'b0, p_lv = 1'b0;
  logic [DW-1:0] p_pix = '0;
  int            p_x = 0, p_y = 0;

  always #5 clk_i = ~clk_i;

  pyramid_sampler #(.DATA_W(DW), .FRAME_W(FW), .FRAME_H(FH), .PATCH(PN)) i_pyramid_sampler (
    .clk_i, .rst_ni, .frame_valid_i, .line_valid_i, .pix_i,
    .frame_valid_o, .line_valid_o, .pix_o, .lvl_valid_o, .lvl_x_o, .lvl_y_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, p_x, p_y);
    end
  endtask

  task automatic build_tables();
    for (int k = 0; k <= PN; k++)
      for (int i = 0; i < PN; i++) hit_t[k][i] = 1'b0;
    // ceil form: j-th sample sits at ceil(PN*j/k)-1
    for (int k = 1; k <= PN / 2; k++)
      for (int j = 1; j <= k; j++) hit_t[k][(PN * j + k - 1) / k - 1] = 1'b1;
    for (int k = PN / 2 + 1; k <= PN; k++)
      for (int i = 0; i < PN; i++) hit_t[k][i] = !hit_t[PN - k][i];
    for (int k = 0; k <= PN; k++) begin
      int c = 0;
      for (int i = 0; i < PN; i++) begin
        rank_t[k][i] = c;
        if (hit_t[k][i]) c++;
      end
    end
  endtask

  task automatic check_outputs();
    logic [PN-1:0] e;
    bit act = p_fv && p_lv;
    chk(pix_o == p_pix, "R2 pix", int'(pix_o), int'(p_pix));
    chk(frame_valid_o == p_fv && line_valid_o == p_lv, "R2 qual",
        int'({frame_valid_o, line_valid_o}), int'({p_fv, p_lv}));
    for (int l = 0; l < PN; l++)
      e[l] = act && hit_t[l+1][p_x % PN] && hit_t[l+1][p_y % PN];
    chk(lvl_valid_o == e, act ? "R3 R4 R9 strobes" : "R8 strobes", int'(lvl_valid_o), int'(e));
    for (int k = 1; k < PN / 2; k++)
      chk(!(lvl_valid_o[k-1] && lvl_valid_o[PN-k-1]), "R4 pair", k, 0);
    for (int l = 0; l < PN; l++) begin
      if (e[l] && lvl_valid_o[l]) begin
        int ex = (p_x / PN) * (l + 1) + rank_t[l+1][p_x % PN];
        int ey = (p_y / PN) * (l + 1) + rank_t[l+1][p_y % PN];
        chk(int'(lvl_x_o[l*XW +: XW]) == ex, "R7 R5 x", int'(lvl_x_o[l*XW +: XW]), ex);
        chk(int'(lvl_y_o[l*YW +: YW]) == ey, "R7 R6 y", int'(lvl_y_o[l*YW +: YW]), ey);
      end
    end
  endtask

  task automatic step(input logic fv, input logic lv, input logic [DW-1:0] px,
                      input int x, input int y);
    @(negedge clk_i);
    check_outputs();
    frame_valid_i = fv;
    line_valid_i  = lv;
    pix_i         = px;
    p_fv = fv; p_lv = lv; p_pix = px; p_x = x; p_y = y;
  endtask

  task automatic run_frame(input int hb, input int vb, input int seed);
    for (int i = 0; i < vb; i++) step(1'b0, 1'b0, DW'(i + seed), 0, 0);
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) step(1'b1, 1'b1, DW'(x * 3 + y * 7 + seed), x, y);
      for (int i = 0; i < hb; i++) step(1'b1, 1'b0, DW'(seed - i), 0, y);
    end
    step(1'b0, 1'b0, '0, 0, 0);
  endtask

  initial begin
    build_tables();
    repeat (3) @(negedge clk_i);
    // R1: quiet outputs while reset is held
    chk(lvl_valid_o == '0, "R1 strobes", int'(lvl_valid_o), 0);
    chk(!frame_valid_o && !line_valid_o && pix_o == '0, "R1 stream",
        int'({frame_valid_o, line_valid_o, pix_o}), 0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, '0, 0, 0);
    run_frame(3, 5, 11);
    // R8: line burst outside a frame must raise nothing
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, DW'(200 + i), i, 0);
    step(1'b0, 1'b0, '0, 0, 0);
    run_frame(1, 2, 57);
    run_frame(6, 1, 90);
    repeat (3) step(1'b0, 1'b0, '0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule